// File: doc/BRIEF.md
# Flash Register Write-Protection Controller

This block holds the status and configuration registers of a serial NOR flash device and decides whether each register write may take effect. The status byte carries a three-bit block-protect field and a register-lock bit. The configuration byte carries a quad-mode bit and a bit that selects whether the block-protect field keeps its value across power loss or comes up fully protected at every power-on.

Commands reach the block already decoded, one per cycle, with both data bytes. A write-enable command arms a latch. A following register-write command is honoured only if the latch is armed and the write is not blocked. A write is blocked when the lock bit is set, the write-protect pin is low and quad mode is off. Every write attempt disarms the latch. A read command returns a snapshot of both bytes. Non-volatile bits live in a shadow store that neither reset input clears. The live register copies are reloaded from that store on a warm reset and on power-on.

Top module: `nor_wp_regs`

## Requirements
- R1: After power-on with the factory shadow contents (all zero), the status byte reads 0x00, the configuration byte reads 0x00, and `wel`, `wr_rej` and `rd_valid` are 0.
- R2: A write-enable command (op 2'b01) sets `wel` from the next cycle on. Every register-write command (op 2'b10) clears `wel` on its edge, whether the write is accepted or rejected.
- R3: A register-write command issued while `wel` is 0 changes neither byte, and `wr_rej` is 1 for exactly the following cycle.
- R4: An accepted write loads these fields from the data bytes: lock bit from status bit 7, block-protect from status bits 4:2, quad-mode from configuration bit 1, and volatility-select from configuration bit 5. All other bits of both bytes read 0.
- R5: With the lock bit at 1, the pin low and quad mode off, a register-write command is ignored: both bytes keep their values and `wr_rej` pulses for one cycle.
- R6: With the pin high, an armed register-write command is accepted even when the lock bit is 1.
- R7: With quad mode on, an armed register-write command is accepted even when the lock bit is 1 and the pin is low.
- R8: The lock, quad-mode and volatility-select bits keep their last written values through both a warm reset and a power-on.
- R9: With volatility-select at 0, the block-protect field keeps its last written value through a warm reset and a power-on.
- R10: With volatility-select at 1 in the shadow store, power-on sets the block-protect field to 3'b111. A warm reset reloads the field from the non-volatile copy. Writes made while volatility-select is 1 (before the write) change only the live field, not the non-volatile copy.
- R11: A read command (op 2'b11) gives `rd_valid` = 1 in the next cycle, with `rd_data` = {configuration, status} as they stood before that edge, whatever the protection state.
- R12: A command presented in a cycle where `rst` or `por` is high is discarded: no register changes from it, `wr_rej` stays 0, and `wel` ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high |
| por | input | 1 | Power-on event, synchronous, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 01 write enable, 10 register write, 11 register read |
| wr_sr | input | 8 | Status data byte for a register write |
| wr_cr | input | 8 | Configuration data byte for a register write |
| wp_n | input | 1 | Write-protect pin level (low protects) |
| sr_out | output | 8 | Live status byte |
| cr_out | output | 8 | Live configuration byte |
| wel | output | 1 | Write-enable latch |
| wr_rej | output | 1 | One-cycle pulse after a rejected register write |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | {configuration, status} snapshot |

## Verification
Two events can fall in the same cycle: a register-write command and a warm reset or power-on. The bench builds this by arming the latch and then raising `rst` or `por` together with the write. It also raises them at random during a seeded random run. A correct result leaves both bytes at their reloaded values, no reject pulse and a cleared latch. A second overlap is a register write that meets both a disarmed latch and an active lock. It is judged by the single reject pulse and the unchanged bytes.

// File: rtl/nor_wp_pkg.sv
package nor_wp_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_WREN = 2'b01,
    OP_WRR  = 2'b10,
    OP_RDR  = 2'b11
  } nor_op_e;

  localparam int SRWD_POS = 7;
  localparam int BP_LSB   = 2;
  localparam int QE_POS   = 1;
  localparam int VS_POS   = 5;
endpackage

// File: rtl/nor_wp_wel.sv
module nor_wp_wel (
  input  logic clk,
  input  logic clr,
  input  logic set_i,
  input  logic wrr_i,
  output logic wel_o
);
  logic wel_q = 1'b0;

  always_ff @(posedge clk) begin
    if (clr)        wel_q <= 1'b0;
    else if (wrr_i) wel_q <= 1'b0;
    else if (set_i) wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  // R2: any write attempt disarms the latch
  a_r2_wel_clears: assert property (@(posedge clk) disable iff (clr)
    wrr_i |=> !wel_o);
endmodule

// File: rtl/nor_wp_gate.sv
module nor_wp_gate (
  input  logic clk,
  input  logic clr,
  input  logic wrr_i,
  input  logic wel_i,
  input  logic srwd_i,
  input  logic qe_i,
  input  logic wp_n_i,
  output logic accept_o,
  output logic rej_o
);
  logic locked;
  logic rej_q = 1'b0;

  // pin protection is active only outside quad mode
  assign locked   = srwd_i & ~wp_n_i & ~qe_i;
  assign accept_o = wrr_i & wel_i & ~locked;

  always_ff @(posedge clk) begin
    if (clr) rej_q <= 1'b0;
    else     rej_q <= wrr_i & ~accept_o;
  end

  assign rej_o = rej_q;

  a_r5_locked_rejects: assert property (@(posedge clk) disable iff (clr)
    (wrr_i && srwd_i && !wp_n_i && !qe_i) |=> rej_o);

  a_r3_unarmed_rejects: assert property (@(posedge clk) disable iff (clr)
    (wrr_i && !wel_i) |=> rej_o);
endmodule

// File: rtl/nor_wp_nvstore.sv
module nor_wp_nvstore #(
  parameter int BP_W = 3
) (
  input  logic            clk,
  input  logic            we,
  input  logic            vs_now,
  input  logic            srwd_d,
  input  logic            qe_d,
  input  logic            vs_d,
  input  logic [BP_W-1:0] bp_d,
  output logic            nv_srwd,
  output logic            nv_qe,
  output logic            nv_vs,
  output logic [BP_W-1:0] nv_bp
);
  // factory contents; no reset input reaches this store
  logic            srwd_q = 1'b0;
  logic            qe_q   = 1'b0;
  logic            vs_q   = 1'b0;
  logic [BP_W-1:0] bp_q   = '0;

  always_ff @(posedge clk) begin
    if (we) begin
      srwd_q <= srwd_d;
      qe_q   <= qe_d;
      vs_q   <= vs_d;
      if (!vs_now) bp_q <= bp_d;
    end
  end

  assign nv_srwd = srwd_q;
  assign nv_qe   = qe_q;
  assign nv_vs   = vs_q;
  assign nv_bp   = bp_q;
endmodule

// File: rtl/nor_wp_regs.sv
module nor_wp_regs
  import nor_wp_pkg::*;
#(
  parameter int BP_W = 3,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            por,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [DW-1:0]   wr_sr,
  input  logic [DW-1:0]   wr_cr,
  input  logic            wp_n,
  output logic [DW-1:0]   sr_out,
  output logic [DW-1:0]   cr_out,
  output logic            wel,
  output logic            wr_rej,
  output logic            rd_valid,
  output logic [2*DW-1:0] rd_data
);
  localparam int BP_MSB = BP_LSB + BP_W - 1;
  localparam logic [DW-1:0] SR_MASK =
    DW'((1 << SRWD_POS) | (((1 << BP_W) - 1) << BP_LSB));

  logic clr;
  logic is_wren, is_wrr, is_rdr;
  logic accept;
  logic nv_srwd, nv_qe, nv_vs;
  logic [BP_W-1:0] nv_bp;

  logic            srwd_q = 1'b0;
  logic            qe_q   = 1'b0;
  logic            vs_q   = 1'b0;
  logic [BP_W-1:0] bp_q   = '0;
  logic            rdv_q  = 1'b0;
  logic [2*DW-1:0] rdd_q  = '0;

  logic unused_data_bits;
  assign unused_data_bits = ^{wr_sr, wr_cr};

  assign clr     = rst | por;
  assign is_wren = cmd_valid & (cmd_op == OP_WREN) & ~clr;
  assign is_wrr  = cmd_valid & (cmd_op == OP_WRR)  & ~clr;
  assign is_rdr  = cmd_valid & (cmd_op == OP_RDR)  & ~clr;

  nor_wp_wel u_wel (
    .clk   (clk),
    .clr   (clr),
    .set_i (is_wren),
    .wrr_i (is_wrr),
    .wel_o (wel)
  );

  nor_wp_gate u_gate (
    .clk      (clk),
    .clr      (clr),
    .wrr_i    (is_wrr),
    .wel_i    (wel),
    .srwd_i   (srwd_q),
    .qe_i     (qe_q),
    .wp_n_i   (wp_n),
    .accept_o (accept),
    .rej_o    (wr_rej)
  );

  nor_wp_nvstore #(.BP_W(BP_W)) u_nv (
    .clk     (clk),
    .we      (accept),
    .vs_now  (vs_q),
    .srwd_d  (wr_sr[SRWD_POS]),
    .qe_d    (wr_cr[QE_POS]),
    .vs_d    (wr_cr[VS_POS]),
    .bp_d    (wr_sr[BP_MSB:BP_LSB]),
    .nv_srwd (nv_srwd),
    .nv_qe   (nv_qe),
    .nv_vs   (nv_vs),
    .nv_bp   (nv_bp)
  );

  // live copies: power-on beats warm reset beats command
  always_ff @(posedge clk) begin
    if (por) begin
      srwd_q <= nv_srwd;
      qe_q   <= nv_qe;
      vs_q   <= nv_vs;
      bp_q   <= nv_vs ? '1 : nv_bp;
    end else if (rst) begin
      srwd_q <= nv_srwd;
      qe_q   <= nv_qe;
      vs_q   <= nv_vs;
      bp_q   <= nv_bp;
    end else if (accept) begin
      srwd_q <= wr_sr[SRWD_POS];
      bp_q   <= wr_sr[BP_MSB:BP_LSB];
      qe_q   <= wr_cr[QE_POS];
      vs_q   <= wr_cr[VS_POS];
    end
  end

  always_comb begin
    sr_out                 = '0;
    sr_out[SRWD_POS]       = srwd_q;
    sr_out[BP_MSB:BP_LSB]  = bp_q;
    cr_out                 = '0;
    cr_out[QE_POS]         = qe_q;
    cr_out[VS_POS]         = vs_q;
  end

  always_ff @(posedge clk) begin
    if (clr) rdv_q <= 1'b0;
    else     rdv_q <= is_rdr;
    if (is_rdr) rdd_q <= {cr_out, sr_out};
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  a_r6_pin_high_accepts: assert property (@(posedge clk) disable iff (rst || por)
    (is_wrr && wel && wp_n) |=> (sr_out == ($past(wr_sr) & SR_MASK)));

  a_r11_read_snapshot: assert property (@(posedge clk) disable iff (rst || por)
    is_rdr |=> (rd_valid && rd_data == $past({cr_out, sr_out})));

  a_r10_poweron_full_protect: assert property (@(posedge clk) disable iff (rst)
    (por && nv_vs) |=> (bp_q == '1));

  a_r5_locked_keeps_status: assert property (@(posedge clk) disable iff (rst || por)
    (is_wrr && srwd_q && !wp_n && !qe_q) |=> $stable(sr_out) && $stable(cr_out));
endmodule

// File: tb/sim_nor_wp_regs.sv
`timescale 1ns/1ps
module sim_nor_wp_regs;
  logic        clk = 1'b0;
  logic        rst, por, cmd_valid, wp_n;
  logic [1:0]  cmd_op;
  logic [7:0]  wr_sr, wr_cr;
  logic [7:0]  sr_out, cr_out;
  logic        wel, wr_rej, rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of the registers
  logic       m_srwd = 0, m_qe = 0, m_vs = 0, m_wel = 0;
  logic [2:0] m_bp = 0;
  logic       n_srwd = 0, n_qe = 0, n_vs = 0;
  logic [2:0] n_bp = 0;
  logic       e_rej = 0, e_rv = 0;
  logic [15:0] e_rd = 0;

  always #2.5 clk = ~clk;

  nor_wp_regs u0 (
    .clk(clk), .rst(rst), .por(por), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .wr_sr(wr_sr), .wr_cr(wr_cr), .wp_n(wp_n), .sr_out(sr_out), .cr_out(cr_out),
    .wel(wel), .wr_rej(wr_rej), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] f_sr();
    return {m_srwd, 2'b00, m_bp, 2'b00};
  endfunction

  function automatic logic [7:0] f_cr();
    return {2'b00, m_vs, 3'b000, m_qe, 1'b0};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic r, input logic p, input logic [1:0] op,
                       input logic [7:0] s, input logic [7:0] c, input logic w);
    e_rej = 0;
    e_rv  = 0;
    if (p) begin
      m_srwd = n_srwd; m_qe = n_qe; m_vs = n_vs;
      m_bp = n_vs ? 3'b111 : n_bp;
      m_wel = 0;
    end else if (r) begin
      m_srwd = n_srwd; m_qe = n_qe; m_vs = n_vs; m_bp = n_bp;
      m_wel = 0;
    end else begin
      case (op)
        2'b01: m_wel = 1;
        2'b10: begin
          if (m_wel && !(m_srwd && !w && !m_qe)) begin
            if (!m_vs) n_bp = s[4:2];
            n_srwd = s[7]; n_qe = c[1]; n_vs = c[5];
            m_srwd = s[7]; m_bp = s[4:2]; m_qe = c[1]; m_vs = c[5];
          end else begin
            e_rej = 1;
          end
          m_wel = 0;
        end
        2'b11: begin
          e_rv = 1;
          e_rd = {f_cr(), f_sr()};
        end
        default: ;
      endcase
    end
  endtask

  task automatic step(input string tag, input logic r, input logic p,
                      input logic [1:0] op, input logic [7:0] s,
                      input logic [7:0] c, input logic w);
    rst = r; por = p; cmd_op = op; cmd_valid = (op != 2'b00);
    wr_sr = s; wr_cr = c; wp_n = w;
    model(r, p, op, s, c, w);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "sr", {8'h00, sr_out}, {8'h00, f_sr()});
    chk(tag, "cr", {8'h00, cr_out}, {8'h00, f_cr()});
    chk(tag, "wel", {15'h0, wel}, {15'h0, m_wel});
    chk(tag, "wr_rej", {15'h0, wr_rej}, {15'h0, e_rej});
    chk(tag, "rd_valid", {15'h0, rd_valid}, {15'h0, e_rv});
    if (e_rv) chk(tag, "rd_data", rd_data, e_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 0; por = 1; cmd_valid = 0; cmd_op = 0; wr_sr = 0; wr_cr = 0; wp_n = 1;
    @(negedge clk);
    // R1: power-on from factory contents
    step("R1", 0, 1, 2'b00, 8'h00, 8'h00, 1);
    step("R1", 0, 0, 2'b00, 8'h00, 8'h00, 1);
    // R2: arm the latch
    step("R2", 0, 0, 2'b01, 8'h00, 8'h00, 1);
    // R4: accepted write, unused bits dropped
    step("R4", 0, 0, 2'b10, 8'hFF, 8'hFF, 1);
    chk("R4", "sr_fixed", {8'h00, sr_out}, 16'h009C);
    chk("R4", "cr_fixed", {8'h00, cr_out}, 16'h0022);
    // R3: write with latch clear
    step("R3", 0, 0, 2'b10, 8'h00, 8'h00, 1);
    step("R3", 0, 0, 2'b00, 8'h00, 8'h00, 1);
    // R6: lock set, pin high -> accepted
    step("R6", 0, 0, 2'b01, 8'h00, 8'h00, 1);
    step("R6", 0, 0, 2'b10, 8'h80, 8'h00, 1);
    chk("R6", "sr_fixed", {8'h00, sr_out}, 16'h0080);
    // R5: lock set, pin low, no quad -> rejected
    step("R5", 0, 0, 2'b01, 8'h00, 8'h00, 0);
    step("R5", 0, 0, 2'b10, 8'h9C, 8'h22, 0);
    chk("R5", "sr_fixed", {8'h00, sr_out}, 16'h0080);
    // R7: quad mode overrides the pin
    step("R7", 0, 0, 2'b01, 8'h00, 8'h00, 1);
    step("R7", 0, 0, 2'b10, 8'h80, 8'h02, 1);
    step("R7", 0, 0, 2'b01, 8'h00, 8'h00, 0);
    step("R7", 0, 0, 2'b10, 8'h8C, 8'h02, 0);
    chk("R7", "sr_fixed", {8'h00, sr_out}, 16'h008C);
    // R8 / R9: survive warm reset and power-on
    step("R8", 1, 0, 2'b00, 8'h00, 8'h00, 0);
    step("R9", 0, 1, 2'b00, 8'h00, 8'h00, 0);
    step("R9", 0, 0, 2'b00, 8'h00, 8'h00, 0);
    chk("R8", "cr_fixed", {8'h00, cr_out}, 16'h0002);
    chk("R9", "sr_fixed", {8'h00, sr_out}, 16'h008C);
    // R10: volatile block-protect
    step("R10", 0, 0, 2'b01, 8'h00, 8'h00, 1);
    step("R10", 0, 0, 2'b10, 8'h00, 8'h20, 1);
    step("R10", 0, 0, 2'b01, 8'h00, 8'h00, 1);
    step("R10", 0, 0, 2'b10, 8'h14, 8'h20, 1);
    step("R10", 1, 0, 2'b00, 8'h00, 8'h00, 1);
    chk("R10", "bp_warm", {13'h0, sr_out[4:2]}, 16'h0000);
    step("R10", 0, 1, 2'b00, 8'h00, 8'h00, 1);
    step("R10", 0, 0, 2'b00, 8'h00, 8'h00, 1);
    chk("R10", "bp_por", {13'h0, sr_out[4:2]}, 16'h0007);
    // R11: read while locked
    step("R11", 0, 0, 2'b01, 8'h00, 8'h00, 1);
    step("R11", 0, 0, 2'b10, 8'h88, 8'h20, 1);
    step("R11", 0, 0, 2'b11, 8'h00, 8'h00, 0);
    chk("R11", "rd_fixed", rd_data, 16'h2088);
    // R12: reset or power-on in the same cycle as a command
    step("R12", 0, 0, 2'b01, 8'h00, 8'h00, 1);
    step("R12", 1, 0, 2'b10, 8'h00, 8'h00, 1);
    step("R12", 0, 0, 2'b01, 8'h00, 8'h00, 1);
    step("R12", 0, 1, 2'b10, 8'h1C, 8'h02, 1);
    step("R12", 0, 0, 2'b11, 8'h00, 8'h00, 1);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic r, p, w;
      logic [1:0] op;
      logic [7:0] s, c;
      string tag;
      r  = ($urandom_range(0, 39) == 0);
      p  = ($urandom_range(0, 49) == 0);
      w  = $urandom_range(0, 1);
      op = 2'($urandom_range(0, 3));
      s  = 8'($urandom);
      c  = 8'($urandom);
      if ((r || p) && op != 2'b00) tag = "R12";
      else if (r || p)             tag = "R8";
      else if (op == 2'b01)        tag = "R2";
      else if (op == 2'b10)        tag = "R5";
      else if (op == 2'b11)        tag = "R11";
      else                         tag = "R9";
      step(tag, r, p, op, s, c, w);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule